// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock with Alarm

This block is a memory-mapped real-time clock. It counts seconds, minutes and hours in packed BCD, together with day of month, month, a two-digit year (the years 2000 to 2099) and a weekday. The clock only starts after software writes a fixed 32-bit unlock key. From then on it advances once per second. The second is made by dividing the system clock by a parameter. The calendar follows month lengths and the rule that every fourth year is a leap year.

A comparator watches the full date and time against a programmed alarm. On a match it raises a sticky flag that software clears by writing a one. A second sticky flag marks every one-second step. Each flag has its own enable, and the interrupt output is the OR of the enabled flags. Software reaches every register through a simple 32-bit bus. Writes take effect on the clock edge and reads are combinational. Writing the time or the date loads the counters directly and restarts the one-second divider.

Top module: `rtc_bcd_cal`

## Requirements
- R1: After reset the unlock register (offset 0x00) reads 0, time (0x0C) reads 0x000000, date (0x10) reads 0x000101, weekday (0x18) reads 6, status (0x2C) reads 0, leap (0x24) reads 1 and irqOut is 0.
- R2: Only a write of 0xA5EB1357 to offset 0x00 sets its bit 0. Any other value leaves it at 0, and while it is 0 the time does not advance.
- R3: Once unlocked, the time advances by one second every TICK_DIV clock cycles. The first step lands TICK_DIV cycles after the unlocking write.
- R4: Time at 0x0C holds BCD seconds in [7:0], minutes in [15:8] and hours in [23:16]. Seconds and minutes wrap from 59 to 00 with a carry, and hours wrap from 23 to 00 with a carry into the day.
- R5: Date at 0x10 holds BCD day in [7:0], month 1..12 in [15:8] and year 00..99 in [23:16]. The day wraps to 01 after 31, 30, 28 or 29 according to the month, and February has 29 days when the year is divisible by 4. Month 12 wraps to 01 and the year steps, with 99 wrapping to 00.
- R6: Weekday at 0x18 (bits [2:0], 0..6) can be written on its own. It steps once on each day change and wraps from 6 to 0.
- R7: A write to time or date loads those fields and restarts the divider, so the next step comes TICK_DIV cycles after the write.
- R8: Bit 0 of offset 0x24 is read-only and reads 1 when the current year is a leap year.
- R9: The alarm registers, time at 0x1C and date at 0x20, use the layouts of 0x0C and 0x10. Status bit 0 (0x2C) sets on the step that makes time and date both equal the alarm. A direct load never sets it, and neither does a step that matches the time on a different date.
- R10: Writing 1 to status bit 0 clears it and writing 0 leaves it unchanged. A set on the same edge as a clear wins.
- R11: Enable register 0x28 bit 0 gates the alarm flag onto irqOut and bit 1 gates the tick flag. irqOut = (status[0] & enable[0]) | (status[1] & enable[1]).
- R12: Status bit 1 sets on every one-second step and clears when 1 is written to it.
- R13: Format register 0x14 reads 1 in bit 0 (24-hour mode) and ignores writes. Unmapped offsets such as 0x04 and 0x08 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access select |
| busWr | input | 1 | Write when high together with busSel |
| busAddr | input | 6 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| irqOut | output | 1 | Interrupt request |

## Verification
The calendar is swept over every month of every year from 00 to 99. Each case is loaded at 23:59:59 on the month's last day and one step is taken, which separates the 28, 29, 30 and 31 day limits, month and year wrap and the weekday wrap. A separate February 28 sweep across all years tells leap years from others. A free run of seventy steps through a year-end midnight checks the seconds, minutes and hours carries against an arithmetic model. The alarm is tried in four cases: with the right time on the wrong date, loaded directly onto its value, reached by a step, and with the enable off. These separate a time-only comparison from a full one, a step-driven set from a load-driven one, and the flag from the gated output.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_UNLOCK   = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_TIME     = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_DATE     = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_FORMAT   = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_WDAY     = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_ALM_TIME = 6'h1C;
  localparam logic [ADDR_W-1:0] OFF_ALM_DATE = 6'h20;
  localparam logic [ADDR_W-1:0] OFF_LEAP     = 6'h24;
  localparam logic [ADDR_W-1:0] OFF_IRQ_EN   = 6'h28;
  localparam logic [ADDR_W-1:0] OFF_IRQ_FLAG = 6'h2C;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'hA5EB1357;

  // number of BCD fields: sec, min, hour, day, month, year
  localparam int NUM_FIELDS = 6;

  // per-field reset value and wrap target (year..sec, index 5..0)
  localparam logic [NUM_FIELDS-1:0][7:0] FIELD_BASE =
    {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  localparam logic [2:0] WDAY_RESET = 3'd6;

  typedef struct packed {
    logic tick;
    logic wrTime;
    logic wrDate;
    logic wrWday;
    logic wrAlmTime;
    logic wrAlmDate;
    logic wrIrqEn;
    logic wrIrqFlag;
  } rtcStrobes_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) bcdInc = {v[7:4] + 4'd1, 4'd0};
    else                bcdInc = {v[7:4], v[3:0] + 4'd1};
  endfunction
endpackage

// File: rtl/rtc_field_cell.sv
module rtc_field_cell #(
  parameter logic [7:0] BASE = 8'h00
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stepIn,
  input  logic [7:0] limit,
  input  logic       load,
  input  logic [7:0] loadVal,
  output logic [7:0] val,
  output logic [7:0] nextVal
);
  always_comb begin
    if (!stepIn)            nextVal = val;
    else if (val == limit)  nextVal = BASE;
    else                    nextVal = rtc_pkg::bcdInc(val);
  end

  always_ff @(posedge clk) begin
    if (!rstN)     val <= BASE;
    else if (load) val <= loadVal;
    else           val <= nextVal;
  end
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int TICK_DIV = 50_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output rtcStrobes_t       stb,
  output logic              active
);
  localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] divCnt;
  logic wrHit;
  logic unlockHit;
  logic restart;

  assign wrHit     = busSel && busWr;
  assign unlockHit = wrHit && (busAddr == OFF_UNLOCK) && (busWdata == UNLOCK_KEY);
  assign restart   = stb.wrTime || stb.wrDate;

  always_comb begin
    stb           = '0;
    stb.wrTime    = wrHit && (busAddr == OFF_TIME);
    stb.wrDate    = wrHit && (busAddr == OFF_DATE);
    stb.wrWday    = wrHit && (busAddr == OFF_WDAY);
    stb.wrAlmTime = wrHit && (busAddr == OFF_ALM_TIME);
    stb.wrAlmDate = wrHit && (busAddr == OFF_ALM_DATE);
    stb.wrIrqEn   = wrHit && (busAddr == OFF_IRQ_EN);
    stb.wrIrqFlag = wrHit && (busAddr == OFF_IRQ_FLAG);
    stb.tick      = active && (divCnt == CNT_MAX) &&
                    !(wrHit && ((busAddr == OFF_TIME) || (busAddr == OFF_DATE)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      divCnt <= '0;
    end else begin
      if (unlockHit) active <= 1'b1;
      if (!active || restart || divCnt == CNT_MAX) divCnt <= '0;
      else                                         divCnt <= divCnt + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rtcStrobes_t       stb,
  input  logic              active,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [23:0]       wdLow,
  output logic [DATA_W-1:0] busRdata,
  output logic [23:0]       curTime,
  output logic [23:0]       curDate,
  output logic [1:0]        irqFlag,
  output logic              irqOut
);
  logic [NUM_FIELDS-1:0][7:0] fieldVal;
  logic [NUM_FIELDS-1:0][7:0] fieldNext;
  logic [NUM_FIELDS-1:0][7:0] fieldLim;
  logic [NUM_FIELDS-1:0]      carry;
  logic [2:0]  wday;
  logic [23:0] almTime;
  logic [23:0] almDate;
  logic [1:0]  irqEn;
  logic        isLeap;
  logic [7:0]  lastDay;
  logic        almMatch;
  logic [1:0]  yrMod4;

  // year divisible by 4: (10*hi + lo) mod 4 == (2*hi[0] + lo) mod 4
  assign yrMod4 = {fieldVal[5][4], 1'b0} + fieldVal[5][1:0];
  assign isLeap = (yrMod4 == 2'b00);

  always_comb begin
    case (fieldVal[4])
      8'h02:                      lastDay = isLeap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: lastDay = 8'h30;
      default:                    lastDay = 8'h31;
    endcase
  end

  assign fieldLim = {8'h99, 8'h12, lastDay, 8'h23, 8'h59, 8'h59};
  assign carry[0] = stb.tick;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    logic       cellLoad;
    logic [7:0] cellLoadVal;
    if (i < 3) begin : g_time
      assign cellLoad    = stb.wrTime;
      assign cellLoadVal = wdLow[8*i +: 8];
    end else begin : g_date
      assign cellLoad    = stb.wrDate;
      assign cellLoadVal = wdLow[8*(i-3) +: 8];
    end
    if (i < NUM_FIELDS - 1) begin : g_carry
      assign carry[i+1] = carry[i] && (fieldVal[i] == fieldLim[i]);
    end
    rtc_field_cell #(.BASE(FIELD_BASE[i])) u_cell (
      .clk    (clk),
      .rstN   (rstN),
      .stepIn (carry[i]),
      .limit  (fieldLim[i]),
      .load   (cellLoad),
      .loadVal(cellLoadVal),
      .val    (fieldVal[i]),
      .nextVal(fieldNext[i])
    );
  end

  assign curTime  = fieldVal[2:0];
  assign curDate  = fieldVal[5:3];
  assign almMatch = (fieldNext[2:0] == almTime) && (fieldNext[5:3] == almDate);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wday    <= WDAY_RESET;
      almTime <= '0;
      almDate <= '0;
      irqEn   <= '0;
      irqFlag <= '0;
    end else begin
      if (stb.wrWday)      wday <= wdLow[2:0];
      else if (carry[3])   wday <= (wday >= 3'd6) ? 3'd0 : wday + 3'd1;
      if (stb.wrAlmTime)   almTime <= wdLow;
      if (stb.wrAlmDate)   almDate <= wdLow;
      if (stb.wrIrqEn)     irqEn   <= wdLow[1:0];
      if (stb.tick && almMatch)            irqFlag[0] <= 1'b1;
      else if (stb.wrIrqFlag && wdLow[0])  irqFlag[0] <= 1'b0;
      if (stb.tick)                        irqFlag[1] <= 1'b1;
      else if (stb.wrIrqFlag && wdLow[1])  irqFlag[1] <= 1'b0;
    end
  end

  assign irqOut = |(irqFlag & irqEn);

  always_comb begin
    case (busAddr)
      OFF_UNLOCK:   busRdata = {31'd0, active};
      OFF_TIME:     busRdata = {8'd0, curTime};
      OFF_DATE:     busRdata = {8'd0, curDate};
      OFF_FORMAT:   busRdata = 32'd1;
      OFF_WDAY:     busRdata = {29'd0, wday};
      OFF_ALM_TIME: busRdata = {8'd0, almTime};
      OFF_ALM_DATE: busRdata = {8'd0, almDate};
      OFF_LEAP:     busRdata = {31'd0, isLeap};
      OFF_IRQ_EN:   busRdata = {30'd0, irqEn};
      OFF_IRQ_FLAG: busRdata = {30'd0, irqFlag};
      default:      busRdata = '0;
    endcase
  end
endmodule

// File: rtl/rtc_bcd_cal.sv
module rtc_bcd_cal
  import rtc_pkg::*;
#(
  parameter int TICK_DIV = 50_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  rtcStrobes_t stb;
  logic        active;
  logic [23:0] curTime;
  logic [23:0] curDate;
  logic [1:0]  irqFlag;

  rtc_ctrl #(.TICK_DIV(TICK_DIV)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .stb     (stb),
    .active  (active)
  );

  rtc_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .active  (active),
    .busAddr (busAddr),
    .wdLow   (busWdata[23:0]),
    .busRdata(busRdata),
    .curTime (curTime),
    .curDate (curDate),
    .irqFlag (irqFlag),
    .irqOut  (irqOut)
  );
endmodule

// File: rtl/rtc_bcd_cal_chk.sv
module rtc_bcd_cal_chk
  import rtc_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input rtcStrobes_t stb,
  input logic        active,
  input logic [23:0] timeVal,
  input logic [1:0]  irqFlag,
  input logic [23:0] wdLow
);
  // R2: a locked clock keeps its time unless software loads it
  assert_hold_when_locked_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !stb.wrTime) |=> $stable(timeVal));

  // R3: the one-second step only happens once unlocked
  assert_step_needs_unlock_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.tick |-> active);

  // R7: a time write lands in the counters on the next edge
  assert_time_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrTime |=> (timeVal == $past(wdLow)));

  // R9: the alarm flag only rises on a step
  assert_alarm_on_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag[0]) |-> $past(stb.tick));

  // R10: writing one clears the alarm flag when no step coincides
  assert_alarm_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrIrqFlag && wdLow[0] && !stb.tick) |=> !irqFlag[0]);
endmodule

bind rtc_bcd_cal rtc_bcd_cal_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .stb    (stb),
  .active (active),
  .timeVal(curTime),
  .irqFlag(irqFlag),
  .wdLow  (busWdata[23:0])
);

// File: tb/rtc_bcd_cal_tb.sv
module rtc_bcd_cal_tb;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  int nChecks = 0;
  int nErr = 0;
  bit done = 1'b0;

  int eS, eMi, eH, eD, eMo, eY, eW;

  always #4 clk = ~clk;

  rtc_bcd_cal #(.TICK_DIV(DIV)) u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  function automatic logic [7:0] toBcd(input int n);
    return 8'((n / 10) * 16 + (n % 10));
  endfunction

  function automatic int daysIn(input int y, input int m);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [31:0] packDate(input int y, input int m, input int d);
    return {8'd0, toBcd(y), toBcd(m), toBcd(d)};
  endfunction

  function automatic logic [31:0] packTime(input int h, input int mi, input int s);
    return {8'd0, toBcd(h), toBcd(mi), toBcd(s)};
  endfunction

  task automatic step();
    eS++;
    if (eS == 60) begin
      eS = 0; eMi++;
      if (eMi == 60) begin
        eMi = 0; eH++;
        if (eH == 24) begin
          eH = 0;
          eW = (eW == 6) ? 0 : eW + 1;
          eD++;
          if (eD > daysIn(eY, eMo)) begin
            eD = 1; eMo++;
            if (eMo == 13) begin
              eMo = 1;
              eY = (eY == 99) ? 0 : eY + 1;
            end
          end
        end
      end
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    busWr = 1'b0; busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic waitTick(input int n);
    repeat (DIV * n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nErr++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(6'h00, v); chk("R1 unlock", v, 32'h0);
    rd(6'h0C, v); chk("R1 time", v, 32'h0);
    rd(6'h10, v); chk("R1 date", v, 32'h000101);
    @(negedge clk);
    rd(6'h18, v); chk("R1 weekday", v, 32'd6);
    rd(6'h2C, v); chk("R1 status", v, 32'd0);
    rd(6'h24, v); chk("R1 leap", v, 32'd1);
    chk("R1 irqOut", {31'd0, irqOut}, 32'd0);
    @(negedge clk);
    // R13 format and unmapped offsets
    rd(6'h14, v); chk("R13 format", v, 32'd1);
    rd(6'h04, v); chk("R13 unmapped 04", v, 32'd0);
    rd(6'h08, v); chk("R13 unmapped 08", v, 32'd0);
    wr(6'h14, 32'h0);
    rd(6'h14, v); chk("R13 format write ignored", v, 32'd1);

    // R2 wrong key leaves clock locked
    wr(6'h00, 32'h12345678);
    rd(6'h00, v); chk("R2 wrong key", v, 32'd0);
    repeat (3 * DIV) @(negedge clk);
    rd(6'h0C, v); chk("R2 locked time holds", v, 32'h0);

    // R2/R3 unlock and first step
    wr(6'h00, 32'hA5EB1357);
    rd(6'h00, v); chk("R2 unlocked", v, 32'd1);
    repeat (DIV - 1) @(negedge clk);
    rd(6'h0C, v); chk("R3 before first step", v, 32'h0);
    @(negedge clk);
    rd(6'h0C, v); chk("R3 first step", v, 32'h1);
    waitTick(1);
    rd(6'h0C, v); chk("R3 second step", v, 32'h2);

    // R7 load restarts the divider
    wr(6'h0C, 32'h000010);
    repeat (DIV - 1) @(negedge clk);
    rd(6'h0C, v); chk("R7 held after load", v, 32'h10);
    @(negedge clk);
    rd(6'h0C, v); chk("R7 step after load", v, 32'h11);

    // R4 free run over a year-end midnight
    eY = 4; eMo = 12; eD = 31; eH = 23; eMi = 58; eS = 55; eW = 3;
    wr(6'h10, packDate(eY, eMo, eD));
    wr(6'h18, 32'(eW));
    wr(6'h0C, packTime(eH, eMi, eS));
    for (int k = 0; k < 70; k++) begin
      step();
      waitTick(1);
      rd(6'h0C, v); chk("R4 run time", v, packTime(eH, eMi, eS));
      rd(6'h10, v); chk("R5 run date", v, packDate(eY, eMo, eD));
      rd(6'h18, v); chk("R6 run weekday", v, 32'(eW));
    end

    // R5/R6/R8 month-end sweep over all years
    for (int y = 0; y < 100; y++) begin
      for (int m = 1; m <= 12; m++) begin
        eY = y; eMo = m; eD = daysIn(y, m); eH = 23; eMi = 59; eS = 59;
        eW = (y + m) % 7;
        wr(6'h10, packDate(eY, eMo, eD));
        wr(6'h18, 32'(eW));
        wr(6'h0C, packTime(eH, eMi, eS));
        step();
        waitTick(1);
        rd(6'h10, v); chk("R5 month end", v, packDate(eY, eMo, eD));
        rd(6'h18, v); chk("R6 weekday wrap", v, 32'(eW));
        rd(6'h0C, v); chk("R4 midnight", v, 32'h0);
        @(negedge clk);
        rd(6'h24, v); chk("R8 leap flag", v, {31'd0, (eY % 4) == 0});
      end
    end

    // R5 February 28 across all years
    for (int y = 0; y < 100; y++) begin
      wr(6'h10, packDate(y, 2, 28));
      wr(6'h0C, 32'h235959);
      waitTick(1);
      rd(6'h10, v);
      chk("R5 feb 28", v, (y % 4 == 0) ? packDate(y, 2, 29) : packDate(y, 3, 1));
    end

    // R9-R11 alarm
    wr(6'h2C, 32'h3);
    wr(6'h28, 32'h0);
    wr(6'h20, packDate(0, 3, 5));
    wr(6'h1C, 32'h102030);
    rd(6'h1C, v); chk("R9 alarm time readback", v, 32'h102030);
    rd(6'h20, v); chk("R9 alarm date readback", v, packDate(0, 3, 5));
    wr(6'h10, packDate(0, 3, 6));
    wr(6'h0C, 32'h102029);
    waitTick(1);
    rd(6'h2C, v); chk("R9 wrong date no flag", v & 32'h1, 32'h0);
    wr(6'h10, packDate(0, 3, 5));
    wr(6'h0C, 32'h102030);
    rd(6'h2C, v); chk("R9 load no flag", v & 32'h1, 32'h0);
    wr(6'h0C, 32'h102029);
    waitTick(1);
    rd(6'h2C, v); chk("R9 alarm flag set", v & 32'h1, 32'h1);
    chk("R11 irq gated off", {31'd0, irqOut}, 32'd0);
    wr(6'h28, 32'h1);
    chk("R11 irq enabled", {31'd0, irqOut}, 32'd1);
    wr(6'h2C, 32'h0);
    rd(6'h2C, v); chk("R10 write zero keeps", v & 32'h1, 32'h1);
    wr(6'h2C, 32'h1);
    rd(6'h2C, v); chk("R10 write one clears", v & 32'h1, 32'h0);
    chk("R11 irq low after clear", {31'd0, irqOut}, 32'd0);

    // R12 tick flag
    wr(6'h28, 32'h2);
    wr(6'h0C, 32'h000000);
    wr(6'h2C, 32'h3);
    rd(6'h2C, v); chk("R12 tick flag cleared", v, 32'h0);
    chk("R12 irq low", {31'd0, irqOut}, 32'd0);
    repeat (2) @(negedge clk);
    rd(6'h2C, v); chk("R12 tick flag set", v, 32'h2);
    chk("R11 tick irq", {31'd0, irqOut}, 32'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule